// File: doc/BRIEF.md
# Filtered Error/Event Queue

This block holds a short first-in first-out list of error and event records for a device status system. Each record carries a 16-bit signed error number and an 8-bit event-type field. A record offered on the push port is kept only if at least one of its event-type bits is also set in the event enable mask supplied alongside it. The status summary logic gets a single not-empty flag, which it places in bit 2 of the summary byte.

A pop returns the oldest record, one cycle later, and removes it from the list. A pop on an empty queue does not underflow. It returns a no-error record instead, in the same format as a real record, with number 0 and type 0. When the eight slots are full, a further accepted push replaces the newest record with a queue-overflow record (number -350). After that, pushes are ignored until a pop frees a slot. A clear command empties the queue.

The occupancy is tracked by a four-state machine:
- `Q_EMPTY`: nothing is stored.
- `Q_PART`: between one and seven records are stored.
- `Q_FULL`: all slots hold real records.
- `Q_OVF`: the queue is full and the newest slot holds the overflow record.

The transitions are:
- *store* (EMPTY→PART, PART→PART): a push is appended.
- *fill* (PART→FULL): the eighth record is appended.
- *drain* (PART→EMPTY): the last record is popped.
- *free* (FULL→PART, OVF→PART): a pop without a push.
- *mark* (FULL→OVF): a push arrives on a full queue.
- *refill* (OVF→FULL): a push and a pop in the same cycle.
- *wipe* (any state→EMPTY): a clear command.

Top module: `errq_top`

## Requirements
- R1: Records are returned in the order they were accepted, and each pop removes the record it returns. `rd_valid` is high, with `rd_code`/`rd_kind`, in the cycle after the edge that sampled `pop`. It is low in every cycle that does not follow a pop.
- R2: A pop while the queue is empty returns `rd_code` = 0 and `rd_kind` = 0 with `rd_valid` high, and the queue stays empty.
- R3: A push is stored only if `(push_kind & event_en) != 0`. Otherwise it has no effect on the contents or on the occupancy.
- R4: `not_empty` is high exactly when at least one record is stored. It is registered and reflects the edge that sampled the push or pop.
- R5: `clear` empties the queue and takes priority over a push or pop in the same cycle. That push is discarded, and that pop gets no response.
- R6: The queue holds 8 records. An accepted push on a full queue without a pop rewrites the newest slot as code -350 (16'hFEA2), type 8'h08. Further pushes are then ignored until a pop.
- R7: A push and a pop in the same cycle on a non-empty queue both complete. The occupancy stays the same, the pop returns the previous head, and the pushed record is appended behind the rest. This holds on a full queue too.
- R8: A push and a pop in the same cycle on an empty queue return the no-error record, and the pushed record is stored.
- R9: After reset the queue is empty, `not_empty` is low and `rd_valid` is low.
- R10: Once an overflow record is in place, a pop frees one slot, and the next accepted push is stored normally behind the overflow record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty the queue |
| push_valid | input | 1 | Offer a record |
| push_code | input | 16 | Signed error number of the offered record |
| push_kind | input | 8 | Event-type bits of the offered record |
| event_en | input | 8 | Event enable mask used to filter pushes |
| pop | input | 1 | Read and remove the oldest record |
| rd_valid | output | 1 | Read response present |
| rd_code | output | 16 | Error number returned by a pop |
| rd_kind | output | 8 | Event type returned by a pop |
| not_empty | output | 1 | At least one record stored (status bit 2) |

## Verification
The read response and the `not_empty` flag are both due one clock edge after the edge that samples `pop`, `push_valid` or `clear`. The bench changes inputs on the falling edge and updates its reference queue just after the rising edge. When a pop is issued, it appends the expected response to a scoreboard. A monitor on the following falling edge removes that entry and compares it against `rd_valid`, `rd_code` and `rd_kind`. In every cycle the same monitor also compares `not_empty` with the reference occupancy, and it flags any response that arrives with nothing queued, or any expected response that does not arrive.

// File: rtl/errq_pkg.sv
`timescale 1ns/1ps
package errq_pkg;

    // Occupancy classes of the record queue.
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2,
        Q_OVF   = 2'd3
    } occ_state_e;

    // Pointer width for a queue of the given depth.
    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/errq_filter.sv
`timescale 1ns/1ps
module errq_filter #(
    parameter int KIND_W = 8
) (
    input  logic              push_valid,
    input  logic [KIND_W-1:0] push_kind,
    input  logic [KIND_W-1:0] event_en,
    output logic              accept
);

    logic [KIND_W-1:0] hit;

    // A record passes when any of its type bits is enabled.
    always_comb begin
        hit    = push_kind & event_en;
        accept = push_valid && (hit != '0);
    end

endmodule

// File: rtl/errq_ctrl.sv
`timescale 1ns/1ps
module errq_ctrl
    import errq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    output logic             wr_en,
    output logic             wr_marker,
    output logic [PTR_W-1:0] wr_idx,
    output logic             rd_en,
    output logic             rd_sentinel,
    output logic [PTR_W-1:0] rd_idx,
    output logic [OCC_W-1:0] occ,
    output occ_state_e       state
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] OCC_ONE  = OCC_W'(1);
    localparam logic [OCC_W-1:0] OCC_NEAR = OCC_W'(DEPTH - 1);
    localparam occ_state_e AFTER_FREE = (DEPTH == 1) ? Q_EMPTY : Q_PART;
    localparam occ_state_e AFTER_STORE = (DEPTH == 1) ? Q_FULL : Q_PART;

    occ_state_e       state_q, state_d;
    logic [PTR_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;
    logic [PTR_W-1:0] newest;
    logic             wr_adv, rd_adv;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        newest = (tail_q == '0) ? LAST_IDX : tail_q - PTR_W'(1);
    end

    // Output decode per state.
    always_comb begin
        wr_en       = 1'b0;
        wr_marker   = 1'b0;
        wr_idx      = tail_q;
        rd_en       = 1'b0;
        rd_sentinel = 1'b0;
        rd_idx      = head_q;
        if (!clear) begin
            unique case (state_q)
                Q_EMPTY: begin
                    wr_en       = push;
                    rd_sentinel = pop;
                end
                Q_PART: begin
                    wr_en = push;
                    rd_en = pop;
                end
                Q_FULL: begin
                    rd_en = pop;
                    if (push && pop) begin
                        wr_en = 1'b1;
                    end else if (push) begin
                        wr_en     = 1'b1;
                        wr_marker = 1'b1;
                        wr_idx    = newest;
                    end
                end
                Q_OVF: begin
                    rd_en = pop;
                    wr_en = push && pop;
                end
                default: begin
                    wr_en = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        wr_adv = wr_en && !wr_marker;
        rd_adv = rd_en;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = Q_EMPTY;
        end else begin
            unique case (state_q)
                Q_EMPTY: begin
                    if (wr_adv) state_d = AFTER_STORE;
                end
                Q_PART: begin
                    if (wr_adv && !rd_adv && occ_q == OCC_NEAR)
                        state_d = Q_FULL;
                    else if (rd_adv && !wr_adv && occ_q == OCC_ONE)
                        state_d = Q_EMPTY;
                end
                Q_FULL: begin
                    if (wr_marker)
                        state_d = Q_OVF;
                    else if (rd_adv && !wr_adv)
                        state_d = AFTER_FREE;
                end
                Q_OVF: begin
                    if (rd_adv && !wr_adv)
                        state_d = AFTER_FREE;
                    else if (rd_adv && wr_adv)
                        state_d = Q_FULL;
                end
                default: state_d = Q_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (wr_adv) tail_q <= step(tail_q);
            if (rd_adv) head_q <= step(head_q);
            if (wr_adv && !rd_adv)      occ_q <= occ_q + OCC_W'(1);
            else if (rd_adv && !wr_adv) occ_q <= occ_q - OCC_W'(1);
        end
    end

    always_comb begin
        occ   = occ_q;
        state = state_q;
    end

    logic unused_full;
    assign unused_full = (OCC_FULL == '0);

endmodule

// File: rtl/errq_store.sv
`timescale 1ns/1ps
module errq_store #(
    parameter int DEPTH      = 8,
    parameter int PTR_W      = 3,
    parameter int CODE_W     = 16,
    parameter int KIND_W     = 8,
    parameter int OVF_CODE   = -350,
    parameter int OVF_KIND   = 8,
    parameter int NOERR_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_marker,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [KIND_W-1:0] wr_kind,
    input  logic              rd_en,
    input  logic              rd_sentinel,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [CODE_W-1:0] rd_code,
    output logic [KIND_W-1:0] rd_kind
);

    localparam logic [CODE_W-1:0] MARK_CODE = CODE_W'(OVF_CODE);
    localparam logic [KIND_W-1:0] MARK_KIND = KIND_W'(OVF_KIND);
    localparam logic [CODE_W-1:0] NONE_CODE = CODE_W'(NOERR_CODE);

    logic [CODE_W-1:0] din_code;
    logic [KIND_W-1:0] din_kind;
    logic [CODE_W-1:0] code_arr [DEPTH];
    logic [KIND_W-1:0] kind_arr [DEPTH];

    always_comb begin
        din_code = wr_marker ? MARK_CODE : wr_code;
        din_kind = wr_marker ? MARK_KIND : wr_kind;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [CODE_W-1:0] code_q;
        logic [KIND_W-1:0] kind_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PTR_W'(gi)) begin
                code_q <= din_code;
                kind_q <= din_kind;
            end
        end
        assign code_arr[gi] = code_q;
        assign kind_arr[gi] = kind_q;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_code  <= NONE_CODE;
            rd_kind  <= '0;
        end else if (rd_en) begin
            rd_valid <= 1'b1;
            rd_code  <= code_arr[rd_idx];
            rd_kind  <= kind_arr[rd_idx];
        end else if (rd_sentinel) begin
            rd_valid <= 1'b1;
            rd_code  <= NONE_CODE;
            rd_kind  <= '0;
        end else begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/errq_top.sv
`timescale 1ns/1ps
module errq_top
    import errq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int CODE_W     = 16,
    parameter int KIND_W     = 8,
    parameter int OVF_CODE   = -350,
    parameter int OVF_KIND   = 8,
    parameter int NOERR_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push_valid,
    input  logic [CODE_W-1:0] push_code,
    input  logic [KIND_W-1:0] push_kind,
    input  logic [KIND_W-1:0] event_en,
    input  logic              pop,
    output logic              rd_valid,
    output logic [CODE_W-1:0] rd_code,
    output logic [KIND_W-1:0] rd_kind,
    output logic              not_empty
);

    localparam int PTR_W = ptr_bits(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic             accept;
    logic             wr_en, wr_marker, rd_en, rd_sentinel;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [OCC_W-1:0] occ;
    occ_state_e       state;

    errq_filter #(.KIND_W(KIND_W)) u_filter (
        .push_valid (push_valid),
        .push_kind  (push_kind),
        .event_en   (event_en),
        .accept     (accept)
    );

    errq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .push        (accept),
        .pop         (pop),
        .wr_en       (wr_en),
        .wr_marker   (wr_marker),
        .wr_idx      (wr_idx),
        .rd_en       (rd_en),
        .rd_sentinel (rd_sentinel),
        .rd_idx      (rd_idx),
        .occ         (occ),
        .state       (state)
    );

    errq_store #(
        .DEPTH(DEPTH), .PTR_W(PTR_W), .CODE_W(CODE_W), .KIND_W(KIND_W),
        .OVF_CODE(OVF_CODE), .OVF_KIND(OVF_KIND), .NOERR_CODE(NOERR_CODE)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_marker   (wr_marker),
        .wr_idx      (wr_idx),
        .wr_code     (push_code),
        .wr_kind     (push_kind),
        .rd_en       (rd_en),
        .rd_sentinel (rd_sentinel),
        .rd_idx      (rd_idx),
        .rd_valid    (rd_valid),
        .rd_code     (rd_code),
        .rd_kind     (rd_kind)
    );

    // Summary flag comes from the occupancy state.
    always_comb begin
        not_empty = (state != Q_EMPTY);
    end

endmodule

// File: rtl/errq_chk.sv
`timescale 1ns/1ps
module errq_chk #(
    parameter int DEPTH  = 8,
    parameter int OCC_W  = 4,
    parameter int CODE_W = 16,
    parameter int KIND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              push_valid,
    input logic [KIND_W-1:0] push_kind,
    input logic [KIND_W-1:0] event_en,
    input logic              pop,
    input logic              rd_valid,
    input logic [CODE_W-1:0] rd_code,
    input logic [KIND_W-1:0] rd_kind,
    input logic              not_empty,
    input logic [OCC_W-1:0]  occ
);

    logic passes;
    assign passes = push_valid && ((push_kind & event_en) != '0);

    // R1
    resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |=> rd_valid);

    // R1
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> !rd_valid);

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear && !not_empty) |=> (rd_valid && rd_code == '0 && rd_kind == '0));

    // R3
    filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !passes && !pop && !clear) |=> $stable(occ));

    // R4
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_empty == (occ != '0));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!not_empty && !rd_valid));

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH) && passes && !pop && !clear) |=> occ == OCC_W'(DEPTH));

    // R7
    swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (passes && pop && not_empty && !clear) |=> $stable(occ));

endmodule

bind errq_top errq_chk #(
    .DEPTH(DEPTH), .OCC_W(OCC_W), .CODE_W(CODE_W), .KIND_W(KIND_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .push_valid (push_valid),
    .push_kind  (push_kind),
    .event_en   (event_en),
    .pop        (pop),
    .rd_valid   (rd_valid),
    .rd_code    (rd_code),
    .rd_kind    (rd_kind),
    .not_empty  (not_empty),
    .occ        (occ)
);

// File: tb/sim_errq_top.sv
`timescale 1ns/1ps
module sim_errq_top;

    localparam int DEPTH = 8;
    localparam logic [15:0] OVF_C = 16'hFEA2;
    localparam logic [7:0]  OVF_K = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_code = '0;
    logic [7:0]  push_kind = '0;
    logic [7:0]  event_en = '0;
    logic        pop = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_code;
    logic [7:0]  rd_kind;
    logic        not_empty;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [15:0] mq_code[$];
    logic [7:0]  mq_kind[$];
    logic [15:0] ex_code[$];
    logic [7:0]  ex_kind[$];
    string       ex_tag[$];

    always #2.5 clk = ~clk;

    errq_top u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push_valid(push_valid),
        .push_code(push_code), .push_kind(push_kind), .event_en(event_en),
        .pop(pop), .rd_valid(rd_valid), .rd_code(rd_code), .rd_kind(rd_kind),
        .not_empty(not_empty)
    );

    task automatic tally(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus; the reference queue updates just after the edge.
    task automatic op(input bit ps, input logic [15:0] c, input logic [7:0] k,
                      input logic [7:0] en, input bit pp, input bit cl, input string tag);
        push_valid = ps; push_code = c; push_kind = k; event_en = en;
        pop = pp; clear = cl;
        @(posedge clk);
        #1;
        if (cl) begin
            mq_code.delete(); mq_kind.delete();
        end else begin
            bit acc;
            acc = ps && ((k & en) != 0);
            if (pp) begin
                if (mq_code.size() == 0) begin
                    ex_code.push_back(16'h0000); ex_kind.push_back(8'h00);
                end else begin
                    ex_code.push_back(mq_code.pop_front());
                    ex_kind.push_back(mq_kind.pop_front());
                end
                ex_tag.push_back(tag);
            end
            if (acc) begin
                if (mq_code.size() < DEPTH) begin
                    mq_code.push_back(c); mq_kind.push_back(k);
                end else begin
                    mq_code[DEPTH-1] = OVF_C; mq_kind[DEPTH-1] = OVF_K;
                end
            end
        end
        @(negedge clk);
        push_valid = 1'b0; pop = 1'b0; clear = 1'b0;
    endtask

    // Monitor: scoreboard compare of responses and the summary flag.
    always @(negedge clk) begin
        if (mon_on) begin
            tally(not_empty == (mq_code.size() != 0), "R4", "not_empty",
                  32'(not_empty), 32'(mq_code.size() != 0));
            if (ex_code.size() != 0) begin
                string t;
                logic [15:0] ec;
                logic [7:0]  ek;
                ec = ex_code.pop_front(); ek = ex_kind.pop_front(); t = ex_tag.pop_front();
                tally(rd_valid, t, "rd_valid", 32'(rd_valid), 32'd1);
                tally(rd_code == ec, t, "rd_code", 32'(rd_code), 32'(ec));
                tally(rd_kind == ek, t, "rd_kind", 32'(rd_kind), 32'(ek));
            end else begin
                tally(!rd_valid, "R1", "unexpected rd_valid", 32'(rd_valid), 32'd0);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R9: reset state
        tally(!not_empty, "R9", "not_empty in reset", 32'(not_empty), 32'd0);
        tally(!rd_valid, "R9", "rd_valid in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        tally(!not_empty, "R9", "not_empty after reset", 32'(not_empty), 32'd0);
        mon_on = 1'b1;

        // R2: empty pops
        op(0, 0, 0, 8'hFF, 1, 0, "R2");
        op(0, 0, 0, 8'hFF, 1, 0, "R2");

        // R1: order
        op(1, 16'd101, 8'h20, 8'hFF, 0, 0, "R1");
        op(1, 16'hFF9C, 8'h10, 8'hFF, 0, 0, "R1");
        op(1, 16'd7, 8'h04, 8'hFF, 0, 0, "R1");
        op(0, 0, 0, 8'hFF, 1, 0, "R1");
        op(0, 0, 0, 8'hFF, 1, 0, "R1");
        op(0, 0, 0, 8'hFF, 1, 0, "R1");
        op(0, 0, 0, 8'hFF, 1, 0, "R2");

        // R3: filtered pushes
        op(1, 16'd55, 8'h20, 8'h01, 0, 0, "R3");
        op(1, 16'd56, 8'h00, 8'hFF, 0, 0, "R3");
        op(1, 16'd57, 8'h81, 8'h80, 0, 0, "R3");
        op(0, 0, 0, 8'hFF, 1, 0, "R3");
        op(0, 0, 0, 8'hFF, 1, 0, "R3");

        // R6: overflow
        for (int i = 0; i < DEPTH + 3; i++)
            op(1, 16'(200 + i), 8'h10, 8'hFF, 0, 0, "R6");
        // R10: free one slot then push behind the marker
        op(0, 0, 0, 8'hFF, 1, 0, "R10");
        op(1, 16'd999, 8'h02, 8'hFF, 0, 0, "R10");
        // R7: swap on a full queue
        op(1, 16'd321, 8'h04, 8'hFF, 1, 0, "R7");
        for (int i = 0; i < DEPTH + 1; i++)
            op(0, 0, 0, 8'hFF, 1, 0, (i >= DEPTH - 3) ? "R10" : "R6");

        // R7: swap on partial queue
        op(1, 16'd1, 8'h01, 8'hFF, 0, 0, "R7");
        op(1, 16'd2, 8'h01, 8'hFF, 1, 0, "R7");
        op(0, 0, 0, 8'hFF, 1, 0, "R7");

        // R8: swap on empty queue
        op(1, 16'd3, 8'h40, 8'hFF, 1, 0, "R8");
        op(0, 0, 0, 8'hFF, 1, 0, "R8");

        // R5: clear wins over push and pop
        op(1, 16'd4, 8'h01, 8'hFF, 0, 0, "R5");
        op(1, 16'd5, 8'h01, 8'hFF, 0, 0, "R5");
        op(1, 16'd6, 8'h01, 8'hFF, 1, 1, "R5");
        op(0, 0, 0, 8'hFF, 1, 0, "R5");

        // Mixed traffic
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], lf ^ 16'h5A5A, {lf[7:4], lf[11:8]}, (lf[3:2] == 0) ? 8'h0F : 8'hFF,
               lf[1] & lf[5], (lf[15:11] == 0), "R1");
        end
        repeat (3) @(negedge clk);
        tally(ex_code.size() == 0, "R1", "pending responses", 32'(ex_code.size()), 32'd0);
        done = 1'b1;
        summary();
    end

endmodule